// File: doc/BRIEF.md
# Codec Register Bank with Read Overrides

This block is the register store on the codec side of an AC'97-style link. The link controller sends it register requests that are already decoded. Each request carries a strobe, a read/write flag, a 7-bit byte address and a 16-bit write word. For every read, the block answers one clock later with three things: a slot 0 tag, an echo of the address for slot 1, and a data word for slot 2. A local processor has its own port onto the same 16-bit storage array. It uses this port to load defaults and inspect what the controller wrote. The processor port is word-indexed (byte address divided by two) and sees raw storage only.

A read from the controller does not always return the stored word. The two extended identity registers report the codec address-select pin in one bit and force the bit above it to zero. The power register reports a live shadow flip-flop for its link-quiet bit, and that flip-flop also drives an output. The three sample-rate registers return one of two fixed rates chosen by an internal flag. In fully-compliant mode every result is ANDed with a per-register mask of defined bits. Odd addresses read back as zero.

There are three resets. The hardware reset clears storage and the shadows. The warm reset clears only the link-quiet bit. A controller write to address 00h is a software reset of the shadows.

Top module: `codec_regbank`

## Requirements
- R1: During and after hardware reset (`rst_n` low), every storage word is 0000h, `link_quiet` is 0, `rsp_valid` is 0 and the sample-rate flag selects BB80h.
- R2: A read request (`ctl_req`=1, `ctl_wr`=0) produces `rsp_valid`=1 for exactly one clock, on the clock after the request. In that cycle `rsp_tag`=3'b111 (bit 2 frame valid, bit 1 slot 1 valid, bit 0 slot 2 valid) and `rsp_addr` equals the requested address. Writes produce no response.
- R3: A controller write to an even address stores all 16 bits. The processor port reads the stored word at `cpu_addr` = byte address / 2, unmodified, in the same cycle.
- R4: A controller read of 28h or 3Ch returns bit 14 equal to `as_pin` in the request cycle and bit 15 as 0, with the other bits from storage. The processor port returns the stored word for these addresses.
- R5: Bit 12 of a controller write to 26h loads `link_quiet`. A read of 26h returns `link_quiet` in bit 12. A `warm_rst` pulse clears `link_quiet` and leaves storage unchanged.
- R6: A controller read of 2Ch, 2Eh or 30h returns AC44h if the last controller write to any of the three carried AC44h. Otherwise it returns BB80h.
- R7: With `fc_mode`=1, results are ANDed with a mask: 00h→03FFh, 02h→BF3Fh, 26h→FF0Fh, 28h and 3Ch→C3FFh, all others FFFFh. With `fc_mode`=0, no mask is applied.
- R8: A read of an odd address returns data 0000h, still with tag 3'b111 and the odd address echoed.
- R9: A controller write to an odd address changes no storage word.
- R10: A controller write to 00h stores its word, clears `link_quiet` and returns the rate flag to BB80h.
- R11: When both ports write the same word in the same cycle, the controller's data is stored.
- R12: Processor writes never change `link_quiet` or the rate flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous active low |
| warm_rst | input | 1 | Warm reset pulse, synchronous active high |
| as_pin | input | 1 | Codec address-select pin level |
| fc_mode | input | 1 | Fully-compliant masking enable |
| ctl_req | input | 1 | Controller request strobe |
| ctl_wr | input | 1 | 1 = write, 0 = read |
| ctl_addr | input | 7 | Controller register byte address |
| ctl_wdata | input | 16 | Controller write word |
| rsp_valid | output | 1 | Read response valid pulse |
| rsp_tag | output | 3 | Slot 0 valid bits {frame, slot1, slot2} |
| rsp_addr | output | 7 | Slot 1 address echo |
| rsp_data | output | 16 | Slot 2 read data |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 6 | Processor word index |
| cpu_wdata | input | 16 | Processor write word |
| cpu_rdata | output | 16 | Processor read word (combinational) |
| link_quiet | output | 1 | Shadow that holds bit clock and serial input low |

## Verification
The assertions assume a read request is a single-cycle strobe. They also assume `as_pin` and the written data are stable at the request edge, because the checks compare against `$past` of these inputs. The one-cycle write-to-shadow check assumes `warm_rst` is low in the write cycle, since the warm reset overrides it. The stimulus raises each request for exactly one clock, changes `as_pin` and `fc_mode` only between requests, and pulses `warm_rst` only when no request is active.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int TAG_W  = 3;

  localparam logic [ADDR_W-1:0] A_SWRESET = 7'h00;
  localparam logic [ADDR_W-1:0] A_MASTER  = 7'h02;
  localparam logic [ADDR_W-1:0] A_POWER   = 7'h26;
  localparam logic [ADDR_W-1:0] A_AUD_ID  = 7'h28;
  localparam logic [ADDR_W-1:0] A_MDM_ID  = 7'h3C;
  localparam logic [ADDR_W-1:0] A_RATE0   = 7'h2C;
  localparam logic [ADDR_W-1:0] A_RATE1   = 7'h2E;
  localparam logic [ADDR_W-1:0] A_RATE2   = 7'h30;

  localparam int QUIET_BIT = 12;
  localparam int PIN_BIT   = 14;
  localparam int ZERO_BIT  = 15;

  localparam logic [DATA_W-1:0] RATE_HI = 16'hBB80;
  localparam logic [DATA_W-1:0] RATE_LO = 16'hAC44;
  localparam logic [TAG_W-1:0]  TAG_ALL = 3'b111;

  function automatic logic is_rate(input logic [ADDR_W-1:0] a);
    return (a == A_RATE0) || (a == A_RATE1) || (a == A_RATE2);
  endfunction

  function automatic logic is_ident(input logic [ADDR_W-1:0] a);
    return (a == A_AUD_ID) || (a == A_MDM_ID);
  endfunction

  function automatic logic [DATA_W-1:0] defined_bits(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] m;
    case (a)
      A_SWRESET:          m = 16'h03FF;
      A_MASTER:           m = 16'hBF3F;
      A_POWER:            m = 16'hFF0F;
      A_AUD_ID, A_MDM_ID: m = 16'hC3FF;
      default:            m = 16'hFFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/crb_store.sv
module crb_store #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int WORDS = 1 << IDX_W;

  logic [WORDS-1:0][DATA_W-1:0] mem_flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              hit_a;
    logic              hit_b;
    logic              word_en;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      hit_a   = a_we && (a_idx == IDX_W'(w));
      hit_b   = b_we && (b_idx == IDX_W'(w));
      word_en = hit_a || hit_b;
      word_d  = hit_a ? a_wdata : b_wdata;   // controller port wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign mem_flat[w] = word_q;
  end

  assign a_rdata = mem_flat[a_idx];
  assign b_rdata = mem_flat[b_idx];
endmodule

// File: rtl/crb_shadow.sv
module crb_shadow
  import codec_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              quiet_q,
  output logic              rate_lo_q
);
  logic quiet_d;
  logic rate_lo_d;
  logic sw_reset;

  always_comb begin
    sw_reset  = wr_en && (wr_addr == A_SWRESET);
    quiet_d   = quiet_q;
    rate_lo_d = rate_lo_q;
    if (wr_en && (wr_addr == A_POWER)) quiet_d   = wr_data[QUIET_BIT];
    if (wr_en && is_rate(wr_addr))     rate_lo_d = (wr_data == RATE_LO);
    if (sw_reset) begin
      quiet_d   = 1'b0;
      rate_lo_d = 1'b0;
    end
    if (warm_rst) quiet_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q   <= 1'b0;
      rate_lo_q <= 1'b0;
    end else begin
      quiet_q   <= quiet_d;
      rate_lo_q <= rate_lo_d;
    end
  end
endmodule

// File: rtl/crb_readout.sv
module crb_readout
  import codec_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ram_word,
  input  logic              as_pin,
  input  logic              fc_mode,
  input  logic              quiet,
  input  logic              rate_lo,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = ram_word;
    if (rd_addr == A_POWER) word_d[QUIET_BIT] = quiet;
    if (is_ident(rd_addr)) begin
      word_d[PIN_BIT]  = as_pin;
      word_d[ZERO_BIT] = 1'b0;
    end
    if (is_rate(rd_addr)) word_d = rate_lo ? RATE_LO : RATE_HI;
    if (fc_mode) word_d = word_d & defined_bits(rd_addr);
    if (rd_addr[0]) word_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) begin
        rsp_tag  <= TAG_ALL;
        rsp_addr <= rd_addr;
        rsp_data <= word_d;
      end
    end
  end
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
  import codec_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              as_pin,
  input  logic              fc_mode,
  input  logic              ctl_req,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              link_quiet
);
  logic              ctl_rd;
  logic              ctl_wen;
  logic              ctl_wany;
  logic [DATA_W-1:0] ctl_word;
  logic              rate_lo;

  assign ctl_rd   = ctl_req && !ctl_wr;
  assign ctl_wany = ctl_req && ctl_wr;
  assign ctl_wen  = ctl_wany && !ctl_addr[0];

  crb_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_we    (ctl_wen),
    .a_idx   (ctl_addr[ADDR_W-1:1]),
    .a_wdata (ctl_wdata),
    .b_we    (cpu_we),
    .b_idx   (cpu_addr),
    .b_wdata (cpu_wdata),
    .a_rdata (ctl_word),
    .b_rdata (cpu_rdata)
  );

  crb_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .wr_en     (ctl_wen),
    .wr_addr   (ctl_addr),
    .wr_data   (ctl_wdata),
    .quiet_q   (link_quiet),
    .rate_lo_q (rate_lo)
  );

  crb_readout u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (ctl_rd),
    .rd_addr   (ctl_addr),
    .ram_word  (ctl_word),
    .as_pin    (as_pin),
    .fc_mode   (fc_mode),
    .quiet     (link_quiet),
    .rate_lo   (rate_lo),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/crb_checker.sv
module crb_checker
  import codec_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              warm_rst,
  input logic              as_pin,
  input logic              ctl_req,
  input logic              ctl_wr,
  input logic [ADDR_W-1:0] ctl_addr,
  input logic [DATA_W-1:0] ctl_wdata,
  input logic              rsp_valid,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [DATA_W-1:0] rsp_data,
  input logic              link_quiet
);
  logic rd;
  assign rd = ctl_req && !ctl_wr;

  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (rsp_valid && rsp_addr == $past(ctl_addr)));
  assert_no_rsp_without_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  assert_tag_all_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_tag == TAG_ALL);
  assert_odd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ctl_addr[0]) |=> rsp_data == '0);
  assert_ident_pin_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_ident(ctl_addr)) |=> (!rsp_data[ZERO_BIT] && rsp_data[PIN_BIT] == $past(as_pin)));
  assert_rate_fixed_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_rate(ctl_addr)) |=> (rsp_data == RATE_HI || rsp_data == RATE_LO));
  assert_warm_clears_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> !link_quiet);
  assert_power_write_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req && ctl_wr && ctl_addr == A_POWER && !warm_rst) |=> link_quiet == $past(ctl_wdata[QUIET_BIT]));
  assert_swreset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req && ctl_wr && ctl_addr == A_SWRESET) |=> !link_quiet);
endmodule

bind codec_regbank crb_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .warm_rst   (warm_rst),
  .as_pin     (as_pin),
  .ctl_req    (ctl_req),
  .ctl_wr     (ctl_wr),
  .ctl_addr   (ctl_addr),
  .ctl_wdata  (ctl_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_tag    (rsp_tag),
  .rsp_addr   (rsp_addr),
  .rsp_data   (rsp_data),
  .link_quiet (link_quiet)
);

// File: tb/codec_regbank_bench.sv
module codec_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        as_pin = 1'b0;
  logic        fc_mode = 1'b1;
  logic        ctl_req = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [6:0]  ctl_addr = '0;
  logic [15:0] ctl_wdata = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_tag;
  logic [6:0]  rsp_addr;
  logic [15:0] rsp_data;
  logic        cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        link_quiet;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  codec_regbank u_codec_regbank (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .as_pin(as_pin), .fc_mode(fc_mode),
    .ctl_req(ctl_req), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .link_quiet(link_quiet)
  );

  // {is_read, byte address, write word, expected read word}; fc_mode=1, as_pin=0
  localparam int NVEC = 16;
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 7'h02, 16'hFFFF, 16'h0000},
    {1'b1, 7'h02, 16'h0000, 16'hBF3F},   // R7 mask on 02h
    {1'b0, 7'h26, 16'h1000, 16'h0000},
    {1'b1, 7'h26, 16'h0000, 16'h1000},   // R5 quiet bit read back
    {1'b0, 7'h2C, 16'hAC44, 16'h0000},
    {1'b1, 7'h2E, 16'h0000, 16'hAC44},   // R6
    {1'b1, 7'h30, 16'h0000, 16'hAC44},   // R6
    {1'b0, 7'h30, 16'h1234, 16'h0000},
    {1'b1, 7'h2C, 16'h0000, 16'hBB80},   // R6
    {1'b0, 7'h28, 16'hFFFF, 16'h0000},
    {1'b1, 7'h28, 16'h0000, 16'h03FF},   // R4 R7
    {1'b1, 7'h05, 16'h0000, 16'h0000},   // R8
    {1'b0, 7'h10, 16'hA5A5, 16'h0000},
    {1'b1, 7'h10, 16'h0000, 16'hA5A5},   // R3
    {1'b0, 7'h2E, 16'hAC44, 16'h0000},
    {1'b1, 7'h30, 16'h0000, 16'hAC44}    // R6
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic ctl_op(input logic wr, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    ctl_req = 1'b1; ctl_wr = wr; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ctl_req = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic ctl_read(input string req, input logic [6:0] a, input logic [15:0] exp);
    ctl_op(1'b0, a, 16'h0);
    check({req, " valid"}, {15'h0, rsp_valid}, 16'h1);
    check({req, " data"}, rsp_data, exp);
  endtask

  task automatic cpu_write(input logic [5:0] i, input logic [15:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = i; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_peek(input string req, input logic [5:0] i, input logic [15:0] exp);
    @(negedge clk);
    cpu_addr = i;
    #1;
    check(req, cpu_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", {15'h0, rsp_valid}, 16'h0);
    check("R1 link_quiet", {15'h0, link_quiet}, 16'h0);
    cpu_peek("R1 storage", 6'h13, 16'h0000);
    rst_n = 1'b1;
    ctl_read("R1 rate flag", 7'h2C, 16'hBB80);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][39]) ctl_read($sformatf("R3 vector %0d", k), VEC[k][38:32], VEC[k][15:0]);
      else            ctl_op(1'b1, VEC[k][38:32], VEC[k][31:16]);
    end

    // R2 response is a single-cycle pulse with full tag and echo
    ctl_read("R8 odd read", 7'h07, 16'h0000);
    check("R2 tag", {13'h0, rsp_tag}, 16'h0007);
    check("R2 addr echo", {9'h0, rsp_addr}, 16'h0007);
    @(negedge clk);
    check("R2 single pulse", {15'h0, rsp_valid}, 16'h0);
    ctl_op(1'b1, 7'h12, 16'h0001);
    check("R2 no rsp on write", {15'h0, rsp_valid}, 16'h0);

    cpu_peek("R3 cpu view", 6'h08, 16'hA5A5);

    // R4 pin reflected, storage untouched
    as_pin = 1'b1;
    ctl_op(1'b1, 7'h3C, 16'h0000);
    ctl_read("R4 pin bit", 7'h3C, 16'h4000);
    cpu_peek("R4 cpu raw", 6'h14, 16'hFFFF);

    // R7 unmasked
    fc_mode = 1'b0;
    ctl_read("R7 unmasked 02h", 7'h02, 16'hFFFF);
    ctl_read("R7 unmasked 28h", 7'h28, 16'h7FFF);
    fc_mode = 1'b1;

    // R5 warm reset clears flop only
    check("R5 quiet set", {15'h0, link_quiet}, 16'h1);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    check("R5 warm clear", {15'h0, link_quiet}, 16'h0);
    ctl_read("R5 read flop", 7'h26, 16'h0000);
    cpu_peek("R5 storage kept", 6'h13, 16'h1000);

    // R12 processor writes leave shadows alone
    cpu_write(6'h13, 16'h1000);
    check("R12 quiet", {15'h0, link_quiet}, 16'h0);
    cpu_write(6'h18, 16'h0000);
    ctl_read("R12 rate", 7'h2C, 16'hAC44);

    // R10 software reset
    ctl_op(1'b1, 7'h26, 16'h1000);
    check("R10 quiet before", {15'h0, link_quiet}, 16'h1);
    ctl_op(1'b1, 7'h00, 16'h1234);
    check("R10 quiet cleared", {15'h0, link_quiet}, 16'h0);
    ctl_read("R10 rate reset", 7'h2E, 16'hBB80);
    cpu_peek("R10 word stored", 6'h00, 16'h1234);

    // R9 odd write ignored
    ctl_op(1'b1, 7'h03, 16'h5555);
    cpu_peek("R9 neighbour kept", 6'h01, 16'hFFFF);

    // R11 collision
    @(negedge clk);
    ctl_req = 1'b1; ctl_wr = 1'b1; ctl_addr = 7'h04; ctl_wdata = 16'h1111;
    cpu_we = 1'b1; cpu_addr = 6'h02; cpu_wdata = 16'h2222;
    @(negedge clk);
    ctl_req = 1'b0; ctl_wr = 1'b0; cpu_we = 1'b0;
    cpu_peek("R11 controller wins", 6'h02, 16'h1111);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 quiet after reset", {15'h0, link_quiet}, 16'h0);
    cpu_peek("R1 storage cleared", 6'h01, 16'h0000);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule